// File: doc/BRIEF.md
# Fractional Clock-Enable Rate Controller

This block turns a free-running clock into a stream of single-cycle enable pulses whose average rate is `mult/32` of the clock, where `mult` can be any value from 1 to 32. Downstream logic qualifies its registers with the enable, so it runs at the reduced rate without a second clock. The pulses are spread evenly: a 5-bit accumulator adds `mult` on every cycle and fires an enable whenever the sum reaches 32. Time is cut into 32-cycle frames. Each frame carries exactly `mult` pulses, and the accumulator returns to zero at every frame end.

Software sees two 32-bit registers. The frequency register (select 0) holds the ratio in bits 12:8 in inverted form: the field stores `32 - mult`, and the value 0 means `mult = 32`. The kick register (select 1) carries an update request in bit 31. To change the rate, software writes the field and then writes 1 to bit 31. The bit then reads as 1 (busy). A two-state controller waits for the last cycle of the current frame. On that edge it loads the new ratio and clears the busy bit. No frame therefore ever mixes two ratios. While busy is set, writes to the field are dropped. All other bits of both registers are plain storage.

Controller states: `CS_IDLE` (no update pending) and `CS_PENDING` (update requested, waiting for the frame end). Transitions: `CS_IDLE -> CS_PENDING` on a kick-register write with bit 31 set. `CS_PENDING -> CS_IDLE` in the last cycle of a frame, which is the commit. Every other case keeps the state, and a kick written in `CS_PENDING` is absorbed.

Top module: `frac_clk_en`

## Requirements
- R1: After reset both registers read 0, so the field encodes mult = 32, busy is clear, and `clk_en_o` is high on every cycle.
- R2: With a stable ratio, any 32 consecutive cycles of `clk_en_o` hold exactly `mult` pulses, where `mult = 32 - F` for field value F in bits 12:8 of the frequency register (F = 0 gives 32).
- R3: Within a frame, cycle k (k = 0..31) carries a pulse exactly when floor((k+1)·mult/32) > floor(k·mult/32), and `clk_en_o` shows that decision one cycle later.
- R4: A write to the kick register with bit 31 set, while idle, makes bit 31 read as 1 from the next cycle.
- R5: A requested ratio takes effect only at a frame boundary. The whole frame before the commit uses the old ratio, and the whole frame after uses the new one. Busy clears on the commit edge, no more than 33 cycles after the kick. The field alone, without a kick, never changes the rate.
- R6: A write to the frequency register while busy leaves bits 12:8 unchanged and stores all other bits.
- R7: Bits other than 12:8 of the frequency register, and bits 30:0 of the kick register, read back exactly as last written.
- R8: Writing 0 to kick bit 31 while busy does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that the enable stream is derived from |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 frequency register, 1 kick register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| clk_en_o | output | 1 | Registered clock-enable pulse stream |

## Verification
The hardest case to reach is the commit edge itself. The ports give no view of the frame counter, so the bench cannot aim at the boundary directly. The bench records every enable sample in a running history and polls the busy bit once per cycle after each kick. The first sample with busy clear marks the boundary. The 32 samples before it must hold the old count, and the next 32 samples are compared pulse by pulse against the accumulator formula for the new ratio. Writes to the field and to the kick bit during the busy window exercise the lockout in the same way.

// File: rtl/fce_pkg.sv
package fce_pkg;
    localparam int FCE_DATA_W    = 32;
    localparam int FCE_FIELD_W   = 5;
    localparam int FCE_FIELD_LSB = 8;
    localparam int FCE_KICK_BIT  = 31;

    typedef enum logic [0:0] {
        CS_IDLE    = 1'b0,
        CS_PENDING = 1'b1
    } commit_state_e;
endpackage

// File: rtl/fce_regs.sv
module fce_regs
    import fce_pkg::*;
#(
    parameter int DATA_W    = FCE_DATA_W,
    parameter int FIELD_W   = FCE_FIELD_W,
    parameter int FIELD_LSB = FCE_FIELD_LSB,
    parameter int KICK_BIT  = FCE_KICK_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               busy,
    output logic [DATA_W-1:0]  rdata,
    output logic [FIELD_W-1:0] field,
    output logic               kick_req
);
    localparam logic [DATA_W-1:0] FIELD_MASK =
        DATA_W'(((64'd1 << FIELD_W) - 64'd1) << FIELD_LSB);
    localparam logic [DATA_W-1:0] KICK_MASK = DATA_W'(64'd1 << KICK_BIT);

    logic [DATA_W-1:0] freq_q;
    logic [DATA_W-1:0] kick_store_q;

    // Frequency register: the ratio field is locked while an update is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
        end else if (wr && !sel) begin
            if (busy)
                freq_q <= (freq_q & FIELD_MASK) | (wdata & ~FIELD_MASK);
            else
                freq_q <= wdata;
        end
    end

    // Kick register: the request bit lives in the controller, the rest is storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kick_store_q <= '0;
        else if (wr && sel)
            kick_store_q <= wdata & ~KICK_MASK;
    end

    always_comb begin
        kick_req = wr && sel && wdata[KICK_BIT];
        field    = freq_q[FIELD_LSB +: FIELD_W];
        if (sel)
            rdata = kick_store_q | (busy ? KICK_MASK : '0);
        else
            rdata = freq_q;
    end
endmodule

// File: rtl/fce_commit_fsm.sv
module fce_commit_fsm
    import fce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick_req,
    input  logic frame_last,
    output logic busy,
    output logic commit
);
    commit_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= CS_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:    if (kick_req)   state_d = CS_PENDING;
            CS_PENDING: if (frame_last) state_d = CS_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state_q == CS_PENDING);
        commit = (state_q == CS_PENDING) && frame_last;
    end
endmodule

// File: rtl/fce_rate_gen.sv
module fce_rate_gen #(
    parameter int FIELD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [FIELD_W:0] new_mult,
    output logic             frame_last,
    output logic             clk_en
);
    localparam logic [FIELD_W:0] FRAME_LEN = (FIELD_W+1)'(1 << FIELD_W);

    logic [FIELD_W-1:0] cnt_q;
    logic [FIELD_W-1:0] acc_q;
    logic [FIELD_W:0]   mult_q;
    logic [FIELD_W:0]   sum;
    logic               fire;

    always_comb begin
        sum        = {1'b0, acc_q} + mult_q;
        fire       = sum[FIELD_W];
        frame_last = &cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            mult_q <= FRAME_LEN;
            clk_en <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            acc_q  <= sum[FIELD_W-1:0];
            clk_en <= fire;
            if (commit)
                mult_q <= new_mult;
        end
    end
endmodule

// File: rtl/frac_clk_en.sv
module frac_clk_en
    import fce_pkg::*;
#(
    parameter int DATA_W    = FCE_DATA_W,
    parameter int FIELD_W   = FCE_FIELD_W,
    parameter int FIELD_LSB = FCE_FIELD_LSB,
    parameter int KICK_BIT  = FCE_KICK_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en_o
);
    localparam logic [FIELD_W:0] FRAME_LEN = (FIELD_W+1)'(1 << FIELD_W);

    logic [FIELD_W-1:0] field;
    logic [FIELD_W:0]   new_mult;
    logic               kick_req;
    logic               busy;
    logic               commit;
    logic               frame_last;

    fce_regs #(
        .DATA_W(DATA_W), .FIELD_W(FIELD_W),
        .FIELD_LSB(FIELD_LSB), .KICK_BIT(KICK_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr),
        .wdata(reg_wdata), .busy(busy), .rdata(reg_rdata),
        .field(field), .kick_req(kick_req)
    );

    fce_commit_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .kick_req(kick_req),
        .frame_last(frame_last), .busy(busy), .commit(commit)
    );

    // Inverted encoding: the stored field is 32 - mult; zero wraps to 32.
    assign new_mult = FRAME_LEN - {1'b0, field};

    fce_rate_gen #(.FIELD_W(FIELD_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .commit(commit), .new_mult(new_mult),
        .frame_last(frame_last), .clk_en(clk_en_o)
    );
endmodule

// File: rtl/fce_checker.sv
module fce_checker #(
    parameter int FIELD_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic [FIELD_W-1:0] field,
    input logic [FIELD_W-1:0] cnt,
    input logic [FIELD_W-1:0] acc,
    input logic [FIELD_W:0]   mult
);
    localparam logic [FIELD_W:0] FRAME_LEN = (FIELD_W+1)'(1 << FIELD_W);

    a_r2_mult_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mult >= 1) && (mult <= FRAME_LEN));

    a_r3_acc_clear_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (acc == '0));

    a_r5_ratio_held_midframe: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(mult));

    a_r5_busy_ends_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt == '0));

    a_r6_field_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(field));
endmodule

bind frac_clk_en fce_checker #(.FIELD_W(FIELD_W)) u_fce_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .field(field),
    .cnt(u_rate.cnt_q), .acc(u_rate.acc_q), .mult(u_rate.mult_q)
);

// File: tb/frac_clk_en_bench.sv
module frac_clk_en_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en_o;
    logic [63:0] hist = '0;
    int          total = 0;
    int          bad = 0;

    frac_clk_en u_frac_clk_en (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en_o(clk_en_o)
    );

    always #10 clk = ~clk;   // 50 MHz
    always @(negedge clk) hist <= {hist[62:0], clk_en_o};

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic reg_read(input logic sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    function automatic logic [31:0] with_field(input logic [31:0] base, input int m);
        logic [4:0] f = 5'((32 - m) % 32);
        return (base & ~32'h0000_1F00) | ({27'd0, f} << 8);
    endfunction

    function automatic bit exp_pulse(input int k, input int m);
        return (((k + 1) * m) / 32) > ((k * m) / 32);
    endfunction

    // Poll busy after a kick, then check the old frame, the boundary and the new frame.
    task automatic await_commit(input int m_old, input int m_new, input string tag);
        int cyc = 0;
        int cnt = 0;
        logic [31:0] rd;
        forever begin
            @(negedge clk); #1;
            reg_read(1'b1, rd);
            if (!rd[31] || cyc > 40) break;
            cyc++;
        end
        check({"R5 commit latency ", tag}, (cyc <= 33) ? 1 : 0, 1);
        check({"R5 old frame intact ", tag}, $countones(hist[31:0]), m_old);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk); #1;
            if (clk_en_o != exp_pulse(k, m_new)) begin
                check({"R3 pulse pattern ", tag}, clk_en_o, exp_pulse(k, m_new));
            end
            cnt += clk_en_o;
        end
        check({"R3 pattern frame ", tag}, 1, 1);
        check({"R2 pulses per frame ", tag}, cnt, m_new);
    endtask

    task automatic t_reset;
        logic [31:0] rd;
        reg_read(1'b0, rd);
        check("R1 freq reg reset", rd, 0);
        reg_read(1'b1, rd);
        check("R1 kick reg reset", rd, 0);
        repeat (40) @(negedge clk);
        #1;
        check("R1 full rate after reset", $countones(hist[31:0]), 32);
    endtask

    task automatic t_change(input int m_old, input int m_new, input logic [31:0] pat);
        logic [31:0] rd;
        reg_write(1'b0, with_field(pat, m_new));
        reg_write(1'b1, 32'h8000_0000);
        reg_read(1'b1, rd);
        check("R4 busy after kick", rd[31], 1);
        await_commit(m_old, m_new, $sformatf("%0d->%0d", m_old, m_new));
    endtask

    task automatic t_storage(input int m_cur);
        logic [31:0] rd;
        reg_write(1'b0, 32'hDEAD_BEEF);
        reg_read(1'b0, rd);
        check("R7 freq reg readback", rd, 32'hDEAD_BEEF);
        reg_write(1'b1, 32'h1234_5678);
        reg_read(1'b1, rd);
        check("R7 kick low bits readback", rd, 32'h1234_5678);
        repeat (40) @(negedge clk);
        #1;
        check("R5 no kick keeps rate", $countones(hist[31:0]), m_cur);
    endtask

    task automatic t_busy_lock(input int m_old);
        logic [31:0] rd;
        reg_write(1'b0, with_field(32'h0000_0000, 7));
        reg_write(1'b1, 32'h8000_0000);
        reg_write(1'b0, with_field(32'hA5A5_A5A5, 20));
        reg_read(1'b0, rd);
        check("R6 field locked while busy", rd[12:8], 5'd25);
        check("R6 other bits stored while busy", rd & ~32'h1F00, 32'hA5A5_A5A5 & ~32'h1F00);
        reg_write(1'b1, 32'h0000_0003);
        reg_read(1'b1, rd);
        check("R8 zero write keeps busy", rd[31], 1);
        check("R7 kick storage while busy", rd[30:0], 3);
        await_commit(m_old, 7, "locked 7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_change(32, 1, 32'h0000_0000);
        t_change(1, 5, 32'hFFFF_FFFF);
        t_change(5, 17, 32'h0F0F_0F0F);
        t_change(17, 31, 32'h0000_0000);
        t_storage(31);
        t_busy_lock(31);
        t_change(7, 32, 32'h0000_0000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule